// File: doc/BRIEF.md
# Nibble Datapath with Banked Index Registers

This block is the execute datapath of a small 4-bit processor core. It holds a 4-bit accumulator, a carry flag and four 4-bit index registers arranged as two pairs: a primary pair (high and low) and a secondary pair. Each operation arrives as a 5-bit code with a valid strobe, an optional 4-bit immediate and a one-bit pair-member select, and it completes in one clock. The datapath adds and subtracts with carry or borrow, performs AND, OR and XOR, rotates the accumulator or an index register through carry, and moves nibbles between the accumulator, the index registers and an external 256-nibble data memory.

A two-state machine holds the bank selection: `BANK_PRI` (after reset) and `BANK_SEC`. The transition `BANK_PRI -> BANK_SEC` is taken on the set-bank operation and `BANK_SEC -> BANK_PRI` on the clear-bank operation; every other operation keeps the state. Operations that name an index register reach the pair picked by this state. Independently of the state, the primary pair always forms the data memory address (high register gives the upper nibble), and the secondary pair is always exported: its high register as a table-lookup pointer and its low register as a peripheral-select pointer.

Top module: `nib_datapath`

## Requirements
- R1: After reset the machine is in `BANK_PRI` (`bank` = 0) and `mem_we` is 0; accumulator, carry and index registers are undefined until written.
- R2: Code 15 (set bank, `BANK_PRI -> BANK_SEC`) makes `bank` 1 and code 16 (clear bank, `BANK_SEC -> BANK_PRI`) makes it 0 after the clock.
- R3: Register-naming operations use `op_sel` (0 = high, 1 = low member) within the pair selected by `bank`: code 19 loads the immediate into that register, code 17 copies it to the accumulator, code 18 copies the accumulator into it.
- R4: `mem_addr` is always {primary high, primary low}; `table_ptr` is always the secondary high register and `periph_sel` the secondary low register, whatever `bank` is.
- R5: Add (code 4 with the immediate, code 2 with `mem_rdata`) writes the 4-bit sum to the accumulator and the carry out of bit 3 to carry.
- R6: Subtract (code 5 immediate, code 3 memory) computes acc + ~B + 1; carry becomes 1 when no borrow occurs and 0 on a borrow.
- R7: AND, OR, XOR with `mem_rdata` (codes 6, 7, 8) write the accumulator and leave carry unchanged.
- R8: Rotate-left of the accumulator (code 9) moves old carry into bit 0 and bit 3 into carry; rotate-right (code 10) moves old carry into bit 3 and bit 0 into carry.
- R9: Rotate-left/right of the index register chosen as in R3 (codes 11/12) use the same 5-bit loop through carry and leave the accumulator alone.
- R10: Code 13 sets carry to 1 and code 14 clears it to 0; carry keeps its value across operations that do not write it (e.g. code 1 load-immediate, code 0 no-op).
- R11: Code 21 (store) raises `mem_we` in the same cycle with `mem_wdata` = accumulator and `mem_addr` as in R4; code 20 loads `mem_rdata` into the accumulator; code 1 loads the immediate.
- R12: With `op_valid` low, no register, flag or bank state changes and `mem_we` stays 0, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code |
| op_sel | input | 1 | Pair member select (0 high, 1 low) |
| op_imm | input | 4 | Immediate nibble |
| mem_rdata | input | 4 | Data memory read nibble at `mem_addr` |
| mem_addr | output | 8 | Data memory address from primary pair |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 4 | Data memory write nibble |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |
| bank | output | 1 | Bank selection (1 = secondary pair) |
| table_ptr | output | 4 | Secondary high register |
| periph_sel | output | 4 | Secondary low register |

## Verification
The hardest situation to reach from the ports is proving that an operation issued in `BANK_SEC` leaves the primary pair untouched while the primary pair still drives the memory address. The stimulus first loads a distinct pattern into the primary pair, switches banks, loads and rotates the secondary registers, and then checks both `mem_addr` and the exported secondary pointers before switching back and reading the primary registers through the accumulator. Carry-only effects are observed by following each flag-writing step with a rotate or a direct look at the `carry` port.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 5;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,
        OP_LDI   = 5'd1,
        OP_ADDM  = 5'd2,
        OP_SUBM  = 5'd3,
        OP_ADDI  = 5'd4,
        OP_SUBI  = 5'd5,
        OP_ANDM  = 5'd6,
        OP_ORM   = 5'd7,
        OP_XORM  = 5'd8,
        OP_RLA   = 5'd9,
        OP_RRA   = 5'd10,
        OP_RLR   = 5'd11,
        OP_RRR   = 5'd12,
        OP_SETC  = 5'd13,
        OP_CLRC  = 5'd14,
        OP_SBANK = 5'd15,
        OP_CBANK = 5'd16,
        OP_LDA   = 5'd17,
        OP_STR   = 5'd18,
        OP_LDR   = 5'd19,
        OP_LDM   = 5'd20,
        OP_STM   = 5'd21
    } op_e;

    typedef enum logic [2:0] {
        AL_PASS, AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_ROL, AL_ROR
    } alu_e;

    typedef enum logic {
        BANK_PRI = 1'b0,
        BANK_SEC = 1'b1
    } bank_e;
endpackage

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  alu_e         fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] sum;

    always_comb begin
        sum  = '0;
        res  = b;
        cout = cin;
        unique case (fn)
            AL_PASS: res = b;
            AL_ADD: begin
                sum  = {1'b0, a} + {1'b0, b};
                res  = sum[W-1:0];
                cout = sum[W];
            end
            AL_SUB: begin
                sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
                res  = sum[W-1:0];
                cout = sum[W];
            end
            AL_AND: res = a & b;
            AL_OR:  res = a | b;
            AL_XOR: res = a ^ b;
            AL_ROL: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            AL_ROR: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            default: res = b;
        endcase
    end
endmodule

// File: rtl/nib_regs.sv
module nib_regs
    import nib_pkg::*;
#(
    parameter int W = NIB_W,
    parameter int N = NREG
) (
    input  logic                clk,
    input  logic                we,
    input  logic [RIDX_W-1:0]   widx,
    input  logic [W-1:0]        wdata,
    input  logic [RIDX_W-1:0]   ridx,
    output logic [W-1:0]        rdata,
    output logic [N-1:0][W-1:0] all_q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && widx == RIDX_W'(g)) begin
                q <= wdata;
            end
        end
        assign all_q[g] = q;
    end

    assign rdata = all_q[ridx];
endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import nib_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic           op_sel,
    input  logic [W-1:0]   op_imm,
    input  logic [W-1:0]   mem_rdata,
    output logic [2*W-1:0] mem_addr,
    output logic           mem_we,
    output logic [W-1:0]   mem_wdata,
    output logic [W-1:0]   acc,
    output logic           carry,
    output logic           bank,
    output logic [W-1:0]   table_ptr,
    output logic [W-1:0]   periph_sel
);
    localparam int IDX_PH = 0;
    localparam int IDX_PL = 1;
    localparam int IDX_SH = 2;
    localparam int IDX_SL = 3;

    bank_e state_q, state_d;
    op_e   op;

    alu_e            alu_fn;
    logic [W-1:0]    alu_a, alu_b, alu_res;
    logic            alu_cout;
    logic            acc_we, cy_alu_we, cy_set, cy_clr, reg_we;
    logic [RIDX_W-1:0]         ridx;
    logic [NREG-1:0][W-1:0]    regs_q;
    logic [W-1:0]    reg_rd;

    assign op   = op_e'(op_code);
    assign ridx = {state_q == BANK_SEC, op_sel};

    // State register: bank selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_PRI;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_PRI: if (op_valid && op == OP_SBANK) state_d = BANK_SEC;
            BANK_SEC: if (op_valid && op == OP_CBANK) state_d = BANK_PRI;
            default:  state_d = BANK_PRI;
        endcase
    end

    // Output / decode process
    always_comb begin
        alu_fn    = AL_PASS;
        alu_a     = acc;
        alu_b     = op_imm;
        acc_we    = 1'b0;
        cy_alu_we = 1'b0;
        cy_set    = 1'b0;
        cy_clr    = 1'b0;
        reg_we    = 1'b0;
        mem_we    = 1'b0;
        if (op_valid) begin
            unique case (op)
                OP_LDI:  acc_we = 1'b1;
                OP_ADDM: begin alu_fn = AL_ADD; alu_b = mem_rdata; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_SUBM: begin alu_fn = AL_SUB; alu_b = mem_rdata; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_ADDI: begin alu_fn = AL_ADD; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_SUBI: begin alu_fn = AL_SUB; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_ANDM: begin alu_fn = AL_AND; alu_b = mem_rdata; acc_we = 1'b1; end
                OP_ORM:  begin alu_fn = AL_OR;  alu_b = mem_rdata; acc_we = 1'b1; end
                OP_XORM: begin alu_fn = AL_XOR; alu_b = mem_rdata; acc_we = 1'b1; end
                OP_RLA:  begin alu_fn = AL_ROL; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_RRA:  begin alu_fn = AL_ROR; acc_we = 1'b1; cy_alu_we = 1'b1; end
                OP_RLR:  begin alu_fn = AL_ROL; alu_a = reg_rd; reg_we = 1'b1; cy_alu_we = 1'b1; end
                OP_RRR:  begin alu_fn = AL_ROR; alu_a = reg_rd; reg_we = 1'b1; cy_alu_we = 1'b1; end
                OP_SETC: cy_set = 1'b1;
                OP_CLRC: cy_clr = 1'b1;
                OP_LDA:  begin alu_b = reg_rd; acc_we = 1'b1; end
                OP_STR:  begin alu_b = acc; reg_we = 1'b1; end
                OP_LDR:  reg_we = 1'b1;
                OP_LDM:  begin alu_b = mem_rdata; acc_we = 1'b1; end
                OP_STM:  mem_we = 1'b1;
                default: ;
            endcase
        end
    end

    nib_alu #(.W(W)) u_alu (
        .fn   (alu_fn),
        .a    (alu_a),
        .b    (alu_b),
        .cin  (carry),
        .res  (alu_res),
        .cout (alu_cout)
    );

    nib_regs #(.W(W), .N(NREG)) u_regs (
        .clk   (clk),
        .we    (reg_we),
        .widx  (ridx),
        .wdata (alu_res),
        .ridx  (ridx),
        .rdata (reg_rd),
        .all_q (regs_q)
    );

    always_ff @(posedge clk) begin
        if (acc_we) acc <= alu_res;
        if (cy_set)         carry <= 1'b1;
        else if (cy_clr)    carry <= 1'b0;
        else if (cy_alu_we) carry <= alu_cout;
    end

    assign bank       = (state_q == BANK_SEC);
    assign mem_addr   = {regs_q[IDX_PH], regs_q[IDX_PL]};
    assign mem_wdata  = acc;
    assign table_ptr  = regs_q[IDX_SH];
    assign periph_sel = regs_q[IDX_SL];
endmodule

// File: rtl/nib_datapath_chk.sv
module nib_datapath_chk
    import nib_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic [OP_W-1:0] op_code,
    input logic           op_sel,
    input logic [3:0]     op_imm,
    input logic [7:0]     mem_addr,
    input logic           mem_we,
    input logic [3:0]     mem_wdata,
    input logic [3:0]     acc,
    input logic           carry,
    input logic           bank
);
    // R2
    bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SBANK) |=> bank);
    // R2
    bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CBANK) |=> !bank);
    // R12
    bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(bank));
    // R12
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !mem_we);
    // R11
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc && op_code == OP_STM));
    // R5
    add_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADDI) |=>
            ({carry, acc} == {1'b0, $past(acc)} + {1'b0, $past(op_imm)}));
    // R7
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ANDM || op_code == OP_ORM || op_code == OP_XORM))
            |=> (carry == $past(carry)));
    // R10
    setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SETC) |=> carry);
    // R10
    clrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLRC) |=> !carry);
    // R4
    addr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LDR && !bank && !op_sel)
            |=> (mem_addr[7:4] == $past(op_imm)));
endmodule

bind nib_datapath nib_datapath_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_sel    (op_sel),
    .op_imm    (op_imm),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .acc       (acc),
    .carry     (carry),
    .bank      (bank)
);

// File: tb/tb_nib_datapath.sv
module tb_nib_datapath;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic       op_sel = 1'b0;
    logic [3:0] op_imm = '0;
    logic [3:0] mem_rdata;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [3:0] mem_wdata, acc, table_ptr, periph_sel;
    logic       carry, bank;

    logic [3:0] mem [256];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_datapath dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_sel(op_sel), .op_imm(op_imm), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .acc(acc), .carry(carry), .bank(bank),
        .table_ptr(table_ptr), .periph_sel(periph_sel)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [4:0] c, input logic s, input logic [3:0] i);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_sel = s; op_imm = i;
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd0;
    endtask

    task automatic t_reset;
        chk("R1 bank", {7'd0, bank}, 8'd0);
        chk("R1 mem_we", {7'd0, mem_we}, 8'd0);
    endtask

    task automatic t_bank;
        do_op(5'd15, 0, 0); chk("R2 set", {7'd0, bank}, 8'd1);
        do_op(5'd16, 0, 0); chk("R2 clear", {7'd0, bank}, 8'd0);
    endtask

    task automatic t_regs;
        do_op(5'd19, 0, 4'h5); do_op(5'd19, 1, 4'hA);
        chk("R4 addr", mem_addr, 8'h5A);
        do_op(5'd15, 0, 0);
        do_op(5'd19, 0, 4'h3); do_op(5'd19, 1, 4'h9);
        chk("R4 table_ptr", {4'd0, table_ptr}, 8'h03);
        chk("R4 periph_sel", {4'd0, periph_sel}, 8'h09);
        chk("R3 addr kept in secondary bank", mem_addr, 8'h5A);
        do_op(5'd17, 0, 0); chk("R3 read secondary", {4'd0, acc}, 8'h03);
        do_op(5'd16, 0, 0);
        do_op(5'd17, 1, 0); chk("R3 read primary", {4'd0, acc}, 8'h0A);
        do_op(5'd1, 0, 4'h7); do_op(5'd18, 0, 0); do_op(5'd18, 0, 0);
        chk("R3 store to primary", mem_addr, 8'h7A);
        do_op(5'd19, 0, 4'h5);
    endtask

    task automatic t_mem;
        do_op(5'd1, 0, 4'h7);
        @(negedge clk);
        op_valid = 1'b1; op_code = 5'd21;
        #1;
        chk("R11 we", {7'd0, mem_we}, 8'd1);
        chk("R11 wdata", {4'd0, mem_wdata}, 8'h07);
        chk("R11 addr", mem_addr, 8'h5A);
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd0;
        do_op(5'd1, 0, 4'h0);
        do_op(5'd20, 0, 0); chk("R11 load", {4'd0, acc}, 8'h07);
    endtask

    task automatic t_add;
        do_op(5'd1, 0, 4'h9); do_op(5'd4, 0, 4'h8);
        chk("R5 add carry", {3'd0, carry, acc}, 8'h11);
        do_op(5'd1, 0, 4'h2); do_op(5'd4, 0, 4'h3);
        chk("R5 add no carry", {3'd0, carry, acc}, 8'h05);
        do_op(5'd1, 0, 4'h9); do_op(5'd2, 0, 0);
        chk("R5 add mem", {3'd0, carry, acc}, 8'h10);
    endtask

    task automatic t_sub;
        do_op(5'd1, 0, 4'h5); do_op(5'd5, 0, 4'h3);
        chk("R6 no borrow", {3'd0, carry, acc}, 8'h12);
        do_op(5'd1, 0, 4'h3); do_op(5'd5, 0, 4'h5);
        chk("R6 borrow", {3'd0, carry, acc}, 8'h0E);
        do_op(5'd1, 0, 4'h4); do_op(5'd3, 0, 0);
        chk("R6 sub mem", {3'd0, carry, acc}, 8'h0D);
        do_op(5'd1, 0, 4'h6); do_op(5'd5, 0, 4'h6);
        chk("R6 equal", {3'd0, carry, acc}, 8'h10);
    endtask

    task automatic t_logic;
        do_op(5'd1, 0, 4'h6); do_op(5'd21, 0, 0);
        do_op(5'd1, 0, 4'hC); do_op(5'd13, 0, 0);
        do_op(5'd6, 0, 0); chk("R7 and", {3'd0, carry, acc}, 8'h14);
        do_op(5'd14, 0, 0);
        do_op(5'd7, 0, 0); chk("R7 or", {3'd0, carry, acc}, 8'h06);
        do_op(5'd8, 0, 0); chk("R7 xor", {3'd0, carry, acc}, 8'h00);
    endtask

    task automatic t_rot;
        do_op(5'd1, 0, 4'h9); do_op(5'd14, 0, 0);
        do_op(5'd9, 0, 0);  chk("R8 rol1", {3'd0, carry, acc}, 8'h12);
        do_op(5'd9, 0, 0);  chk("R8 rol2", {3'd0, carry, acc}, 8'h05);
        do_op(5'd10, 0, 0); chk("R8 ror1", {3'd0, carry, acc}, 8'h12);
        do_op(5'd10, 0, 0); chk("R8 ror2", {3'd0, carry, acc}, 8'h09);
    endtask

    task automatic t_rotreg;
        do_op(5'd15, 0, 0);
        do_op(5'd19, 1, 4'h1); do_op(5'd13, 0, 0);
        do_op(5'd12, 1, 0);
        chk("R9 ror reg", {3'd0, carry, periph_sel}, 8'h18);
        chk("R9 acc kept", {4'd0, acc}, 8'h09);
        do_op(5'd11, 1, 0);
        chk("R9 rol reg", {3'd0, carry, periph_sel}, 8'h11);
        chk("R9 primary kept", mem_addr, 8'h5A);
        do_op(5'd16, 0, 0);
    endtask

    task automatic t_hold;
        do_op(5'd13, 0, 0);
        do_op(5'd1, 0, 4'h0); do_op(5'd0, 0, 0);
        chk("R10 hold", {7'd0, carry}, 8'd1);
        do_op(5'd14, 0, 0);
        do_op(5'd17, 0, 0);
        chk("R10 clear", {7'd0, carry}, 8'd0);
    endtask

    task automatic t_ignore;
        do_op(5'd1, 0, 4'h4);
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd21; op_imm = 4'hF;
        #1;
        chk("R12 no we", {7'd0, mem_we}, 8'd0);
        @(negedge clk); op_code = 5'd15;
        @(negedge clk); op_code = 5'd1;
        @(negedge clk); op_code = 5'd13;
        @(negedge clk); op_code = 5'd0;
        chk("R12 bank kept", {7'd0, bank}, 8'd0);
        chk("R12 acc kept", {3'd0, carry, acc}, 8'h04);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 4'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_bank();
        t_regs();
        t_mem();
        t_add();
        t_sub();
        t_logic();
        t_rot();
        t_rotreg();
        t_hold();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule